// File: doc/BRIEF.md
# Split-Cascade Weight-Stationary Multiply-Accumulate Grid

This block is a parameterised grid of multiply-accumulate cells with `M_DIM` rows and `K_DIM` columns. It multiplies a stationary weight matrix by a stream of activation vectors. Weights are shifted in from the left edge, one value per row on each accepted load beat, and each cell then holds its weight for as many activation vectors as follow. An activation vector of `K_DIM` signed elements is presented on one cycle. Element `c` is delayed by `c` cycles and then moves down column `c`, one row per cycle. Partial sums move rightward along each row, one column per cycle. Each cell adds the product of its held weight and the activation passing through it.

The reduction chain of every row is cut between column `SPLIT-1` and column `SPLIT`. The left part, columns `0..SPLIT-1`, forms the low sub-chain. The right part, columns `SPLIT..K_DIM-1`, forms the high sub-chain and starts again from zero. The two results leave on separate ports with separate valid strobes. Each result port is de-skewed per row so that all `M_DIM` row sums of one vector appear in the same cycle. The two halves of a wide reduction can therefore be read independently, or added downstream to form the full dot product.

Top module: `sa_ws_grid`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `lo_valid_o` and `hi_valid_o` are 0 and every row of `lo_o` and `hi_o` reads 0.
- R2: Each accepted load beat shifts the weights of every row one column to the right, and `w_col_i[r]` enters column 0 of row `r`. After `K_DIM` accepted beats, the cell in row `r`, column `c` holds the value that was on `w_col_i[r]` at beat number `K_DIM-1-c` (counting from 0).
- R3: For a vector `a` presented with `act_valid_i`, `lo_o[r]` equals the signed sum over `c < SPLIT` of `w[r][c]*a[c]`.
- R4: `hi_o[r]` equals the signed sum over `c >= SPLIT` of `w[r][c]*a[c]`. Activations in low columns never reach `hi_o`, and activations in high columns never reach `lo_o`.
- R5: `lo_valid_o` rises exactly `M_DIM-1+SPLIT` cycles after the vector is presented, and all `M_DIM` rows of that result are on `lo_o` in that same cycle.
- R6: `hi_valid_o` rises exactly `M_DIM+K_DIM-1` cycles after the vector is presented, and all rows are on `hi_o` in that same cycle.
- R7: Vectors may be presented back to back or with gaps. Each vector yields exactly one low and one high result. Results come out in input order, and each low result comes before its high result.
- R8: A load beat is ignored when `act_valid_i` is high in the same cycle. It is also ignored during the `M_DIM+K_DIM-1` cycles that follow the last cycle with `act_valid_i` high. An ignored beat leaves every held weight unchanged.
- R9: Without new accepted load beats, every later vector is multiplied by the same held weights.
- R10: Operands are two's complement. The accumulator width is `WB+AB+clog2(K_DIM)`, so sums at the extremes of the operand range come out exact.
- R11: Neither valid strobe is asserted unless a vector was presented within the last `M_DIM+K_DIM-1` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Weight load beat request |
| w_col_i | input | M_DIM*WB | One signed weight per row, entering column 0 |
| act_valid_i | input | 1 | Activation vector present this cycle |
| act_i | input | K_DIM*AB | One signed activation per column |
| lo_valid_o | output | 1 | Low sub-chain result valid |
| lo_o | output | M_DIM*ACC_W | Per-row sums over columns below SPLIT |
| hi_valid_o | output | 1 | High sub-chain result valid |
| hi_o | output | M_DIM*ACC_W | Per-row sums over columns from SPLIT up |

## Verification
The bench builds the grid with 4 rows, 4 columns, the cut at column 2 and 8-bit operands. This gives latencies of 5 and 7 cycles and an 18-bit accumulator. At that size, one-hot activation vectors read back every weight position on the two result ports. Load requests can be held across the whole busy window, up to its last cycle. Weights and activations at -128 and 127 push the accumulator width to its limit. A sweep over several random weight matrices, each with back-to-back and gapped vectors, is compared against sums computed in the bench.

// File: rtl/sa_ws_pkg.sv
package sa_ws_pkg;

  function automatic int acc_width(input int wb, input int ab, input int terms);
    return wb + ab + $clog2(terms);
  endfunction

endpackage

// File: rtl/sa_ws_delay.sv
module sa_ws_delay #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];

endmodule

// File: rtl/sa_ws_cell.sv
module sa_ws_cell #(
  parameter int WB = 8,
  parameter int AB = 8,
  parameter int PW = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic signed [WB-1:0] w_i,
  output logic signed [WB-1:0] w_o,
  input  logic signed [AB-1:0] act_i,
  output logic signed [AB-1:0] act_o,
  input  logic signed [PW-1:0] psum_i,
  output logic signed [PW-1:0] psum_o
);

  logic signed [WB-1:0]    w_q;
  logic signed [AB-1:0]    act_q;
  logic signed [PW-1:0]    psum_q;
  logic signed [WB+AB-1:0] prod;

  assign prod = w_q * act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q    <= '0;
      act_q  <= '0;
      psum_q <= '0;
    end else begin
      if (load_i) w_q <= w_i;
      act_q  <= act_i;
      psum_q <= psum_i + PW'(prod);
    end
  end

  assign w_o    = w_q;
  assign act_o  = act_q;
  assign psum_o = psum_q;

endmodule

// File: rtl/sa_ws_grid.sv
module sa_ws_grid
  import sa_ws_pkg::*;
#(
  parameter int M_DIM = 32,
  parameter int K_DIM = 32,
  parameter int SPLIT = 16,
  parameter int WB    = 8,
  parameter int AB    = 8,
  parameter int ACC_W = acc_width(WB, AB, K_DIM)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [M_DIM-1:0][WB-1:0]    w_col_i,
  input  logic                        act_valid_i,
  input  logic [K_DIM-1:0][AB-1:0]    act_i,
  output logic                        lo_valid_o,
  output logic [M_DIM-1:0][ACC_W-1:0] lo_o,
  output logic                        hi_valid_o,
  output logic [M_DIM-1:0][ACC_W-1:0] hi_o
);

  localparam int LAT_LO  = M_DIM - 1 + SPLIT;
  localparam int LAT_HI  = M_DIM + K_DIM - 1;
  localparam int DRAIN_W = $clog2(LAT_HI + 1);

  // load guard: weights frozen while any vector is in flight
  logic [DRAIN_W-1:0] drain_q;
  logic               busy;
  logic               load_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               drain_q <= '0;
    else if (act_valid_i)      drain_q <= DRAIN_W'(LAT_HI);
    else if (drain_q != '0)    drain_q <= drain_q - 1'b1;
  end

  assign busy    = act_valid_i | (drain_q != '0);
  assign load_ok = load_i & ~busy;

  logic signed [AB-1:0]    act_v [M_DIM+1][K_DIM];
  logic signed [WB-1:0]    w_h   [M_DIM][K_DIM+1];
  logic signed [ACC_W-1:0] ps_h  [M_DIM][K_DIM+1];

  // input skew: column c lags column 0 by c cycles
  for (genvar c = 0; c < K_DIM; c++) begin : g_skew
    if (c == 0) begin : g_direct
      assign act_v[0][c] = act_i[c];
    end else begin : g_dly
      sa_ws_delay #(.WIDTH(AB), .DEPTH(c)) u_skew (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (act_i[c]),
        .q_o   (act_v[0][c])
      );
    end
  end

  for (genvar r = 0; r < M_DIM; r++) begin : g_row
    assign w_h[r][0]  = w_col_i[r];
    assign ps_h[r][0] = '0;
    for (genvar c = 0; c < K_DIM; c++) begin : g_col
      logic signed [ACC_W-1:0] ps_in;
      // cascade cut: high sub-chain restarts from zero
      assign ps_in = (c == SPLIT) ? '0 : ps_h[r][c];
      sa_ws_cell #(.WB(WB), .AB(AB), .PW(ACC_W)) u_cell (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .load_i(load_ok),
        .w_i   (w_h[r][c]),
        .w_o   (w_h[r][c+1]),
        .act_i (act_v[r][c]),
        .act_o (act_v[r+1][c]),
        .psum_i(ps_in),
        .psum_o(ps_h[r][c+1])
      );
    end

    // output de-skew: row r waits M_DIM-1-r cycles
    if (r == M_DIM - 1) begin : g_out_direct
      assign lo_o[r] = ps_h[r][SPLIT];
      assign hi_o[r] = ps_h[r][K_DIM];
    end else begin : g_out_dly
      sa_ws_delay #(.WIDTH(ACC_W), .DEPTH(M_DIM - 1 - r)) u_lo_dsk (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (ps_h[r][SPLIT]),
        .q_o   (lo_o[r])
      );
      sa_ws_delay #(.WIDTH(ACC_W), .DEPTH(M_DIM - 1 - r)) u_hi_dsk (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (ps_h[r][K_DIM]),
        .q_o   (hi_o[r])
      );
    end
  end

  sa_ws_delay #(.WIDTH(1), .DEPTH(LAT_LO)) u_lo_vld (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (act_valid_i),
    .q_o   (lo_valid_o)
  );

  sa_ws_delay #(.WIDTH(1), .DEPTH(LAT_HI)) u_hi_vld (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (act_valid_i),
    .q_o   (hi_valid_o)
  );

endmodule

// File: rtl/sa_ws_grid_chk.sv
module sa_ws_grid_chk #(
  parameter int LAT_HI = 63
) (
  input logic clk_i,
  input logic rst_ni,
  input logic act_valid_i,
  input logic lo_valid_o,
  input logic hi_valid_o
);

  localparam int QW = $clog2(LAT_HI + 2) + 1;

  logic [31:0]   in_cnt, lo_cnt, hi_cnt;
  logic [QW-1:0] quiet;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt <= '0;
      lo_cnt <= '0;
      hi_cnt <= '0;
      quiet  <= '0;
    end else begin
      in_cnt <= in_cnt + 32'(act_valid_i);
      lo_cnt <= lo_cnt + 32'(lo_valid_o);
      hi_cnt <= hi_cnt + 32'(hi_valid_o);
      if (act_valid_i)                   quiet <= '0;
      else if (quiet <= QW'(LAT_HI))     quiet <= quiet + 1'b1;
    end
  end

  assert_lo_has_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_valid_o |-> (in_cnt > lo_cnt));

  assert_hi_has_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_valid_o |-> (in_cnt > hi_cnt));

  assert_lo_before_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_valid_o |-> (lo_cnt > hi_cnt));

  assert_quiet_no_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet > QW'(LAT_HI)) |-> (!lo_valid_o && !hi_valid_o));

endmodule

bind sa_ws_grid sa_ws_grid_chk #(.LAT_HI(M_DIM + K_DIM - 1)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .act_valid_i(act_valid_i),
  .lo_valid_o (lo_valid_o),
  .hi_valid_o (hi_valid_o)
);

// File: tb/sa_ws_grid_bench.sv
`timescale 1ns/1ps
module sa_ws_grid_bench;

  localparam int M      = 4;
  localparam int K      = 4;
  localparam int S      = 2;
  localparam int WB     = 8;
  localparam int AB     = 8;
  localparam int ACC    = sa_ws_pkg::acc_width(WB, AB, K);
  localparam int LAT_LO = M - 1 + S;
  localparam int LAT_HI = M + K - 1;
  localparam int NV     = 256;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    load_i = 1'b0;
  logic [M-1:0][WB-1:0]    w_col_i = '0;
  logic                    act_valid_i = 1'b0;
  logic [K-1:0][AB-1:0]    act_i = '0;
  logic                    lo_valid_o, hi_valid_o;
  logic [M-1:0][ACC-1:0]   lo_o, hi_o;

  sa_ws_grid #(.M_DIM(M), .K_DIM(K), .SPLIT(S), .WB(WB), .AB(AB)) u_sa_ws_grid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .w_col_i    (w_col_i),
    .act_valid_i(act_valid_i),
    .act_i      (act_i),
    .lo_valid_o (lo_valid_o),
    .lo_o       (lo_o),
    .hi_valid_o (hi_valid_o),
    .hi_o       (hi_o)
  );

  always #2.5 clk_i = ~clk_i;

  int          checks = 0, errors = 0, cyc = 0;
  int          tx = 0, rx_lo = 0, rx_hi = 0;
  int          wm [M][K];
  int          exp_lo [NV][M];
  int          exp_hi [NV][M];
  int          in_cyc [NV];
  string       tag [NV];
  string       cur_tag = "R3 R4";
  bit          done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hff) - 128;
  endfunction

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic drain();
    idle(LAT_HI + 1);
  endtask

  // one vector; optional concurrent load request with junk weights
  task automatic send(input int a[K], input bit with_load);
    for (int c = 0; c < K; c++) act_i[c] = AB'(a[c]);
    act_valid_i = 1'b1;
    load_i      = with_load;
    for (int r = 0; r < M; r++) w_col_i[r] = WB'(55 + r);
    for (int r = 0; r < M; r++) begin
      int slo, shi;
      slo = 0;
      shi = 0;
      for (int c = 0; c < K; c++) begin
        if (c < S) slo += wm[r][c] * a[c];
        else       shi += wm[r][c] * a[c];
      end
      exp_lo[tx][r] = slo;
      exp_hi[tx][r] = shi;
    end
    in_cyc[tx] = cyc;
    tag[tx]    = cur_tag;
    tx++;
    tick();
    act_valid_i = 1'b0;
    load_i      = 1'b0;
  endtask

  task automatic send_rand();
    int a[K];
    for (int c = 0; c < K; c++) a[c] = rnd8();
    send(a, 1'b0);
  endtask

  // R2: beat j carries column K-1-j
  task automatic load_mat(input int w[M][K]);
    for (int j = 0; j < K; j++) begin
      load_i = 1'b1;
      for (int r = 0; r < M; r++) w_col_i[r] = WB'(w[r][K-1-j]);
      tick();
    end
    load_i = 1'b0;
    wm = w;
  endtask

  task automatic load_rand();
    int w[M][K];
    for (int r = 0; r < M; r++)
      for (int c = 0; c < K; c++) w[r][c] = rnd8();
    load_mat(w);
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (lo_valid_o) begin
        if (rx_lo < tx) begin
          for (int r = 0; r < M; r++) begin
            int got;
            got = $signed(lo_o[r]);
            chk(got == exp_lo[rx_lo][r], $sformatf("%s R3 lo vec %0d row %0d", tag[rx_lo], rx_lo, r),
                got, exp_lo[rx_lo][r]);
          end
          chk(cyc - in_cyc[rx_lo] == LAT_LO, "R5 lo latency", cyc - in_cyc[rx_lo], LAT_LO);
        end else begin
          chk(1'b0, "R7 extra lo result", rx_lo, tx);
        end
        rx_lo++;
      end
      if (hi_valid_o) begin
        if (rx_hi < tx) begin
          for (int r = 0; r < M; r++) begin
            int got;
            got = $signed(hi_o[r]);
            chk(got == exp_hi[rx_hi][r], $sformatf("%s R4 hi vec %0d row %0d", tag[rx_hi], rx_hi, r),
                got, exp_hi[rx_hi][r]);
          end
          chk(cyc - in_cyc[rx_hi] == LAT_HI, "R6 hi latency", cyc - in_cyc[rx_hi], LAT_HI);
        end else begin
          chk(1'b0, "R7 extra hi result", rx_hi, tx);
        end
        rx_hi++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", rx_hi, tx);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a[K];
    int w[M][K];

    // R1: reset state
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(!lo_valid_o && !hi_valid_o, "R1 valids in reset", int'(lo_valid_o) + int'(hi_valid_o), 0);
    chk(lo_o == '0, "R1 lo in reset", int'(lo_o != '0), 0);
    chk(hi_o == '0, "R1 hi in reset", int'(hi_o != '0), 0);
    @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!lo_valid_o && !hi_valid_o, "R1 valids after release", int'(lo_valid_o) + int'(hi_valid_o), 0);
    chk(lo_o == '0 && hi_o == '0, "R1 outputs after release", int'(lo_o != '0) + int'(hi_o != '0), 0);
    tick();

    // R7: back-to-back stream
    load_rand();
    cur_tag = "R7";
    for (int v = 0; v < 6; v++) send_rand();

    // R9: gapped stream, same weights, no reload
    cur_tag = "R9";
    for (int v = 0; v < 3; v++) begin
      send_rand();
      idle(v + 1);
    end
    drain();

    // R8: load beats with vectors and through the busy window
    cur_tag = "R8";
    for (int v = 0; v < 3; v++) begin
      for (int c = 0; c < K; c++) a[c] = rnd8();
      send(a, 1'b1);
    end
    for (int i = 0; i < LAT_HI; i++) begin
      load_i = 1'b1;
      for (int r = 0; r < M; r++) w_col_i[r] = WB'(-77 + r);
      tick();
    end
    load_i = 1'b0;
    drain();
    for (int v = 0; v < 2; v++) send_rand();
    drain();

    // R2: position probe with one-hot vectors
    for (int r = 0; r < M; r++)
      for (int c = 0; c < K; c++) w[r][c] = ((c % 2) != 0) ? -(r * K + c + 1) : (r * K + c + 1);
    load_mat(w);
    cur_tag = "R2";
    for (int c = 0; c < K; c++) begin
      for (int j = 0; j < K; j++) a[j] = (j == c) ? 3 : 0;
      send(a, 1'b0);
    end

    // R4: only high columns driven, low result must be zero
    cur_tag = "R4 cut";
    for (int j = 0; j < K; j++) a[j] = (j >= S) ? 100 : 0;
    send(a, 1'b0);
    for (int j = 0; j < K; j++) a[j] = (j < S) ? -90 : 0;
    send(a, 1'b0);
    drain();

    // R10: operand extremes
    for (int r = 0; r < M; r++)
      for (int c = 0; c < K; c++) w[r][c] = (r == 0) ? 127 : -128;
    load_mat(w);
    cur_tag = "R10";
    for (int j = 0; j < K; j++) a[j] = -128;
    send(a, 1'b0);
    for (int j = 0; j < K; j++) a[j] = 127;
    send(a, 1'b0);
    for (int j = 0; j < K; j++) a[j] = ((j % 2) != 0) ? 127 : -128;
    send(a, 1'b0);
    drain();

    // sweep over several weight sets
    cur_tag = "R3 R4 sweep";
    for (int m = 0; m < 6; m++) begin
      load_rand();
      for (int v = 0; v < 8; v++) begin
        send_rand();
        if ((v % 3) == 2) idle(1);
      end
      drain();
    end

    drain();
    chk(rx_lo == tx, "R7 lo result count", rx_lo, tx);
    chk(rx_hi == tx, "R7 hi result count", rx_hi, tx);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule